// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block runs one serial-flash transaction each time software asks for one. Software first fills a small byte-wide register set: an opcode, up to four address bytes, a data byte count, a direction and a choice between two flash devices. It then sets a start bit. The engine lowers the chosen chip select and clocks out the opcode. It then sends the address bytes, most significant first, and moves the data bytes between a 256-byte staging buffer and the single-lane serial bus. A busy bit tells software when the transfer has ended.

After reset the block is in direct mode, and in that mode start requests are ignored. Software reaches manual command mode with a guarded step. It writes 0x55 and then 0xAA to the command byte, and then writes the control byte with both mode bits clear. Transactions with no address (status reads and writes) and transactions with no data (erase-style commands) use the same path.

The serial clock runs at half the system clock in mode 0: it idles low, the master changes MOSI while SCLK is low, and it samples MISO on the rising edge.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset the control byte (offset 0x4) reads 0x30, meaning direct mode with bits 5:4 = 11. Both chip selects are high, and SCLK and MOSI are low.
- R2: Manual mode (control bits 5:4 = 00) is entered only when a control write with bits 5:4 = 00 follows a write of 0x55 and then 0xAA to the command byte (offset 0x5). Without that sequence the mode stays unchanged. A control write with bits 5:4 = 11 always returns the block to direct mode. A start request made in direct mode is ignored.
- R3: A control write with bit 0 (start) set is accepted only in manual mode while the engine is idle. After an accepted write, bit 0 reads 1 for one cycle and then 0. Bit 1 (busy) then reads 1 until the chip select is released. A start written while busy is ignored.
- R4: Each transaction sends, in this order: the opcode (offset 0x5); then N address bytes, most significant first, taken from the low N bytes of the address word (offsets 0x8 to 0xB, least significant byte first); then the data bytes. N is config bits 18:16 (offset 0x2, bits 2:0), and values 5 to 7 act as 4. N = 0 gives opcode then data.
- R5: SCLK is low when idle and toggles every system clock while busy. Each bit spends one cycle low and then one cycle high, so each byte takes 16 cycles. MOSI holds its value through the high phase. The transaction ends after a high phase.
- R6: Config bit 24 (offset 0x3, bit 0) chooses the device: 0 drives cs_n[0] low and 1 drives cs_n[1] low. Exactly one chip select is low, only while busy, and it is held for the whole transaction.
- R7: With control bit 3 = 1 (write), the data bytes sent are buffer bytes 0 to count-1, in order.
- R8: With control bit 3 = 0 (read), MOSI is low during the data bytes. Each received byte, sampled on the rising SCLK edges and most significant bit first, goes into buffer bytes 0 to count-1. The buffer is read at bus addresses 0x100 + index.
- R9: The 16-bit count (offset 0x6 low byte, offset 0x7 high byte) equal to 0 gives a transaction with no data phase. A count above 256 moves exactly 256 bytes.
- R10: While a transaction is pending or running, writes to registers and to the buffer have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 9 | Byte address: bit 8 = 1 selects the staging buffer, otherwise registers 0x0 to 0xF |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low chip selects for the two devices |

## Verification
The hardest case to reach is the clamped transfer. It needs a full 256-byte buffer and a count above the buffer depth, and the bench then follows all 4,112 serial cycles of the frame. The bench fills the whole buffer through the bus and programs a count of 300. Its reference model then predicts every SCLK, MOSI and chip-select value for the whole frame. Writes made during a transaction are a second hard case. The bench places start, command and buffer writes inside the busy window of a write-direction transaction. It then reads the register and buffer contents back after busy falls.

// File: rtl/sfc_pkg.sv
// Shared types and encodings for the serial flash command sequencer.
// Assumes byte-wide register access with a 4-bit register offset.
package sfc_pkg;

    localparam logic [3:0] REG_CTRL   = 4'h4;
    localparam logic [3:0] REG_CMD    = 4'h5;
    localparam logic [3:0] REG_CNT_LO = 4'h6;
    localparam logic [3:0] REG_CNT_HI = 4'h7;

    localparam logic [7:0] UNLOCK_FIRST  = 8'h55;
    localparam logic [7:0] UNLOCK_SECOND = 8'hAA;

    localparam logic [1:0] MODE_MANUAL = 2'b00;
    localparam logic [1:0] MODE_DIRECT = 2'b11;

    typedef enum logic [1:0] {
        UNL_IDLE,
        UNL_HALF,
        UNL_ARMED
    } unlock_t;

    // One transaction description, as programmed by software.
    typedef struct packed {
        logic [7:0]  opcode;
        logic [31:0] addr;
        logic [2:0]  addr_bytes;
        logic [15:0] count;
        logic        dir_write;
        logic        cs_sel;
    } xfer_t;

endpackage

// File: rtl/sfc_regs.sv
// Register file for the sequencer: config, control, command, count and address.
// Also holds the manual-mode unlock tracker and the start pulse.
// Assumes register offsets are in addr[3:0] and buffer accesses set addr[AW-1].
// Every write is dropped while a transaction is pending or running.
module sfc_regs
    import sfc_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          busy,
    output logic [7:0]    rdata,
    output xfer_t         xfer,
    output logic          start_q,
    output logic          blocked
);

    logic [31:0] cfg_q;
    logic [31:0] adr_q;
    logic [15:0] cnt_q;
    logic [7:0]  cmd_q;
    logic [1:0]  mode_q;
    logic        dir_q;
    unlock_t     unl_q;

    logic [3:0]  off;
    logic        hit;

    assign off     = addr[3:0];
    assign hit     = ~addr[AW-1] & (addr[AW-2:4] == '0);
    assign blocked = busy | start_q;

    // Register writes, unlock tracking and the self-clearing start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            adr_q   <= '0;
            cnt_q   <= '0;
            cmd_q   <= '0;
            mode_q  <= MODE_DIRECT;
            dir_q   <= 1'b0;
            start_q <= 1'b0;
            unl_q   <= UNL_IDLE;
        end else begin
            start_q <= 1'b0;
            if (we && hit && !blocked) begin
                if (off[3:2] == 2'b00) begin
                    cfg_q[{off[1:0], 3'b000} +: 8] <= wdata;
                end else if (off[3:2] == 2'b10) begin
                    adr_q[{off[1:0], 3'b000} +: 8] <= wdata;
                end else if (off == REG_CTRL) begin
                    dir_q   <= wdata[3];
                    start_q <= wdata[0] & (mode_q == MODE_MANUAL);
                    unl_q   <= UNL_IDLE;
                    if (wdata[5:4] == MODE_DIRECT)
                        mode_q <= MODE_DIRECT;
                    else if (wdata[5:4] == MODE_MANUAL && unl_q == UNL_ARMED)
                        mode_q <= MODE_MANUAL;
                end else if (off == REG_CMD) begin
                    cmd_q <= wdata;
                    if (wdata == UNLOCK_FIRST)
                        unl_q <= UNL_HALF;
                    else if (wdata == UNLOCK_SECOND && unl_q == UNL_HALF)
                        unl_q <= UNL_ARMED;
                    else
                        unl_q <= UNL_IDLE;
                end else if (off == REG_CNT_LO) begin
                    cnt_q[7:0] <= wdata;
                end else if (off == REG_CNT_HI) begin
                    cnt_q[15:8] <= wdata;
                end
            end
        end
    end

    // Register read mux; unmapped offsets read zero.
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (off[3:2])
                2'b00: rdata = cfg_q[{off[1:0], 3'b000} +: 8];
                2'b10: rdata = adr_q[{off[1:0], 3'b000} +: 8];
                2'b01: begin
                    case (off[1:0])
                        2'b00:   rdata = {2'b00, mode_q, dir_q, 1'b0, busy, start_q};
                        2'b01:   rdata = cmd_q;
                        2'b10:   rdata = cnt_q[7:0];
                        default: rdata = cnt_q[15:8];
                    endcase
                end
                default: rdata = '0;
            endcase
        end
    end

    assign xfer = '{opcode:     cmd_q,
                    addr:       adr_q,
                    addr_bytes: cfg_q[18:16],
                    count:      cnt_q,
                    dir_write:  dir_q,
                    cs_sel:     cfg_q[24]};

endmodule

// File: rtl/sfc_buffer.sv
// Staging buffer: one write port and two combinational read ports
// (one for the bus, one for the serial engine).
// The storage is not reset; software fills it before sending it.
module sfc_buffer #(
    parameter int DEPTH = 256,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [7:0]    rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] mem [DEPTH];

    // Single write port.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];

endmodule

// File: rtl/sfc_shifter.sv
// Serial engine: sends opcode, address bytes and data bytes in mode 0
// with SCLK at half the system clock. Each bit is one low cycle and then
// one high cycle. MISO is captured at the end of the high cycle.
// Assumes the transaction description is held stable while busy.
module sfc_shifter
    import sfc_pkg::*;
#(
    parameter int DEPTH          = 256,
    parameter int MAX_ADDR_BYTES = 4,
    parameter int IW             = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  xfer_t         xfer,
    input  logic          miso,
    input  logic [7:0]    buf_rdata,
    output logic [IW-1:0] buf_ridx,
    output logic          buf_we,
    output logic [IW-1:0] buf_widx,
    output logic [7:0]    buf_wdata,
    output logic          busy,
    output logic          sclk,
    output logic          mosi,
    output logic [1:0]    cs_n
);

    localparam int CNT_W = IW + 1;
    localparam int POS_W = IW + 2;

    logic             busy_q;
    logic             sclk_q;
    logic [2:0]       bit_q;
    logic [POS_W-1:0] pos_q;
    logic [7:0]       sh_q;
    logic [6:0]       rx_q;

    logic [2:0]       nab;
    logic [POS_W-1:0] nab_w;
    logic [CNT_W-1:0] nd;
    logic [POS_W-1:0] total;
    logic [POS_W-1:0] fetch_pos;
    logic [1:0]       adr_sel;
    logic [7:0]       fetch_byte;
    logic             cur_is_data;
    logic [7:0]       rx_byte;

    // Transaction length after clamping the address and data byte counts.
    always_comb begin
        nab   = (xfer.addr_bytes > 3'(MAX_ADDR_BYTES)) ? 3'(MAX_ADDR_BYTES) : xfer.addr_bytes;
        nab_w = POS_W'(nab);
        nd    = (xfer.count > 16'(DEPTH)) ? CNT_W'(DEPTH) : xfer.count[CNT_W-1:0];
        total = POS_W'(1) + nab_w + POS_W'(nd);
    end

    // Choose the next byte to send: opcode, address byte or data byte.
    always_comb begin
        fetch_pos = busy_q ? pos_q + POS_W'(1) : '0;
        adr_sel   = nab[1:0] - fetch_pos[1:0];
        buf_ridx  = IW'(fetch_pos - POS_W'(1) - nab_w);
        if (fetch_pos == '0)
            fetch_byte = xfer.opcode;
        else if (fetch_pos <= nab_w)
            fetch_byte = xfer.addr[{adr_sel, 3'b000} +: 8];
        else if (xfer.dir_write)
            fetch_byte = buf_rdata;
        else
            fetch_byte = 8'h00;
    end

    // Store a received byte at the end of each read-data byte.
    always_comb begin
        cur_is_data = pos_q > nab_w;
        rx_byte     = {rx_q, miso};
        buf_we      = busy_q & sclk_q & (bit_q == 3'd7) & cur_is_data & ~xfer.dir_write;
        buf_widx    = IW'(pos_q - POS_W'(1) - nab_w);
        buf_wdata   = rx_byte;
    end

    // Bit and byte sequencing of the serial frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            bit_q  <= '0;
            pos_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
        end else if (!busy_q) begin
            sclk_q <= 1'b0;
            bit_q  <= '0;
            pos_q  <= '0;
            if (start) begin
                busy_q <= 1'b1;
                sh_q   <= fetch_byte;
            end
        end else if (!sclk_q) begin
            sclk_q <= 1'b1;
        end else begin
            sclk_q <= 1'b0;
            rx_q   <= rx_byte[6:0];
            if (bit_q == 3'd7) begin
                bit_q <= '0;
                if (pos_q == total - POS_W'(1)) begin
                    busy_q <= 1'b0;
                end else begin
                    pos_q <= pos_q + POS_W'(1);
                    sh_q  <= fetch_byte;
                end
            end else begin
                bit_q <= bit_q + 3'd1;
                sh_q  <= {sh_q[6:0], 1'b0};
            end
        end
    end

    assign busy = busy_q;
    assign sclk = sclk_q;
    assign mosi = busy_q & sh_q[7];
    assign cs_n = busy_q ? (xfer.cs_sel ? 2'b01 : 2'b10) : 2'b11;

endmodule

// File: rtl/spi_flash_seq.sv
// Top of the serial flash command sequencer. It joins the register file,
// the staging buffer and the serial engine. Bus addresses with the top bit
// set reach the buffer, and all others reach the registers. The serial
// engine has priority on the buffer write port. Bus writes are dropped
// while a transaction is pending or running.
module spi_flash_seq
    import sfc_pkg::*;
#(
    parameter int DEPTH          = 256,
    parameter int MAX_ADDR_BYTES = 4,
    parameter int IW             = $clog2(DEPTH),
    parameter int BUS_AW         = IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [1:0]        spi_cs_n
);

    xfer_t         xfer;
    logic          start_q;
    logic          blocked;
    logic          eng_busy;
    logic [7:0]    reg_rdata;
    logic [7:0]    bus_buf_rdata;
    logic [IW-1:0] eng_ridx;
    logic [7:0]    eng_rdata;
    logic          eng_we;
    logic [IW-1:0] eng_widx;
    logic [7:0]    eng_wdata;
    logic          buf_we;
    logic [IW-1:0] buf_widx;
    logic [7:0]    buf_wdata;

    sfc_regs #(.AW(BUS_AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .busy    (eng_busy),
        .rdata   (reg_rdata),
        .xfer    (xfer),
        .start_q (start_q),
        .blocked (blocked)
    );

    // Buffer write port: the serial engine first, then the bus when idle.
    always_comb begin
        buf_we    = eng_we | (bus_we & bus_addr[BUS_AW-1] & ~blocked);
        buf_widx  = eng_we ? eng_widx  : bus_addr[IW-1:0];
        buf_wdata = eng_we ? eng_wdata : bus_wdata;
    end

    sfc_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .we      (buf_we),
        .widx    (buf_widx),
        .wdata   (buf_wdata),
        .ridx_a  (bus_addr[IW-1:0]),
        .rdata_a (bus_buf_rdata),
        .ridx_b  (eng_ridx),
        .rdata_b (eng_rdata)
    );

    sfc_shifter #(.DEPTH(DEPTH), .MAX_ADDR_BYTES(MAX_ADDR_BYTES)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_q),
        .xfer      (xfer),
        .miso      (spi_miso),
        .buf_rdata (eng_rdata),
        .buf_ridx  (eng_ridx),
        .buf_we    (eng_we),
        .buf_widx  (eng_widx),
        .buf_wdata (eng_wdata),
        .busy      (eng_busy),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .cs_n      (spi_cs_n)
    );

    assign bus_rdata = bus_addr[BUS_AW-1] ? bus_buf_rdata : reg_rdata;

endmodule

// File: rtl/sfc_checker.sv
// Timing and chip-select properties of the serial side, bound to the top.
module sfc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       sclk,
    input logic       mosi,
    input logic [1:0] cs_n
);

    AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n == 2'b11);                                    // R6
    AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $countones(~cs_n) == 1);                            // R6
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(cs_n));                      // R6
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);                                            // R5
    AST_SCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> sclk != $past(sclk));                // R5
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sclk |-> $stable(mosi));                             // R5
    AST_END_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(sclk));                                // R5

endmodule

bind spi_flash_seq sfc_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (eng_busy),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .cs_n  (spi_cs_n)
);

// File: tb/tb_spi_flash_seq.sv
`timescale 1ns/1ps
module tb_spi_flash_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [8:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;
    logic [1:0] spi_cs_n;

    spi_flash_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model state
    int m_mode = 3;
    int m_unl = 0;
    int m_dir = 0;
    int m_cmd = 0;
    int m_cnt = 0;
    int m_cfg [4];
    int m_adrb [4];
    int m_buf [256];
    int mq [$];
    int rq [$];
    bit m_act = 1'b0;
    int m_cyc = 0;
    int m_tot = 0;
    int m_nab = 0;
    int m_rd = 0;
    int m_sel = 0;
    int m_trid = 0;
    int e_busy, e_sclk, e_mosi, e_cs, bidx;

    task automatic finish_tb();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch();
        int nab, nd;
        nab = m_cfg[2] & 7;
        if (nab > 4) nab = 4;
        nd = (m_cnt > 256) ? 256 : m_cnt;
        m_tot = 1 + nab + nd;
        m_nab = nab;
        m_rd = (m_dir == 0);
        m_sel = m_cfg[3] & 1;
        mq.delete();
        rq.delete();
        mq.push_back(m_cmd);
        for (int i = 0; i < nab; i++) mq.push_back(m_adrb[nab - 1 - i]);
        for (int i = 0; i < nd; i++) mq.push_back(m_dir ? m_buf[i] : 0);
        for (int k = 0; k < m_tot; k++) rq.push_back((k * 29 + 'h5A + m_trid * 13) & 'hFF);
        m_trid++;
        m_cyc = -2;
        m_act = 1'b1;
    endtask

    task automatic model_write(input int a, input int d);
        bit acc;
        if (m_act) return;
        if (a >= 256) begin
            m_buf[a - 256] = d;
        end else if (a < 16) begin
            case (a)
                0, 1, 2, 3: m_cfg[a] = d;
                8, 9, 10, 11: m_adrb[a - 8] = d;
                4: begin
                    acc = d[0] && (m_mode == 0);
                    m_dir = d[3];
                    if (d[5:4] == 2'b11) m_mode = 3;
                    else if (d[5:4] == 2'b00 && m_unl == 2) m_mode = 0;
                    m_unl = 0;
                    if (acc) launch();
                end
                5: begin
                    m_cmd = d;
                    if (d == 'h55) m_unl = 1;
                    else if (d == 'hAA && m_unl == 1) m_unl = 2;
                    else m_unl = 0;
                end
                6: m_cnt = (m_cnt & 'hFF00) | d;
                7: m_cnt = (m_cnt & 'h00FF) | (d << 8);
                default: ;
            endcase
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = a[8:0];
        bus_wdata = d[7:0];
        @(posedge clk);
        #0.5;
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(negedge clk);
        bus_addr = a[8:0];
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wait_idle();
        while (m_act) @(negedge clk);
    endtask

    // Program and start a transaction, then check start and busy readback.
    task automatic start_xfer(input int sel, input int nab_raw, input int adr,
                              input int op, input int cnt, input int dir);
        wr(3, sel);
        wr(2, nab_raw);
        for (int i = 0; i < 4; i++) wr(8 + i, (adr >> (8 * i)) & 'hFF);
        wr(5, op);
        wr(6, cnt & 'hFF);
        wr(7, (cnt >> 8) & 'hFF);
        wr(4, dir ? 'h09 : 'h01);
        rd(4, (dir << 3) | 1, "R3 start bit self-clear");
        rd(4, (dir << 3) | 2, "R3 busy set");
    endtask

    task automatic end_xfer(input int dir);
        wait_idle();
        rd(4, dir << 3, "R3 busy cleared");
    endtask

    // Cycle-by-cycle comparison of the serial pins against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (m_act) m_cyc++;
            e_busy = (m_act && m_cyc >= 0 && m_cyc < 16 * m_tot) ? 1 : 0;
            e_sclk = e_busy ? (m_cyc % 2) : 0;
            bidx = e_busy ? m_cyc / 2 : 0;
            e_mosi = e_busy ? ((mq[bidx / 8] >> (7 - bidx % 8)) & 1) : 0;
            e_cs = e_busy ? (m_sel ? 1 : 2) : 3;
            chk("R5 sclk", spi_sclk, e_sclk);
            chk("R4 R7 R8 R9 mosi", spi_mosi, e_mosi);
            chk("R6 cs_n", spi_cs_n, e_cs);
            spi_miso = e_busy ? (((rq[bidx / 8] >> (7 - bidx % 8)) & 1) != 0) : 1'b0;
            if (m_act && m_cyc == 16 * m_tot) begin
                if (m_rd)
                    for (int k = m_nab + 1; k < m_tot; k++) m_buf[k - 1 - m_nab] = rq[k];
                m_act = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog actual=running expected=idle");
        finish_tb();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_cfg[i] = 0;
            m_adrb[i] = 0;
        end
        for (int i = 0; i < 256; i++) m_buf[i] = 0;
        repeat (4) @(posedge clk);
        #0.5 rst_n = 1'b1;

        // R1 reset state
        rd(4, 'h30, "R1 control after reset");
        chk("R1 cs_n after reset", spi_cs_n, 3);
        chk("R1 sclk after reset", spi_sclk, 0);
        chk("R1 mosi after reset", spi_mosi, 0);

        // R2 start in direct mode is ignored
        wr(5, 'h9F);
        wr(4, 'h31);
        repeat (20) @(negedge clk);
        rd(4, 'h30, "R2 start ignored in direct mode");

        // R2 broken unlock sequence leaves the mode unchanged
        wr(5, 'h55);
        wr(5, 'h12);
        wr(5, 'hAA);
        wr(4, 'h00);
        rd(4, 'h30, "R2 broken unlock");

        // R2 proper unlock
        wr(5, 'h55);
        wr(5, 'hAA);
        wr(4, 'h00);
        rd(4, 'h00, "R2 manual mode entered");

        // A: status read, no address, cs0 (R4 R8)
        start_xfer(0, 0, 0, 'h05, 2, 0);
        end_xfer(0);
        rd('h100, m_buf[0], "R8 read byte 0");
        rd('h101, m_buf[1], "R8 read byte 1");

        // Fill the whole buffer
        for (int i = 0; i < 256; i++) wr('h100 + i, (i * 7 + 3) & 'hFF);
        rd('h1FF, m_buf[255], "R7 buffer fill readback");

        // B: page write, cs1, 3 address bytes, with writes during busy (R4 R6 R7 R10)
        start_xfer(1, 3, 'h00123456, 'h02, 5, 1);
        wr(4, 'h09);
        wr(5, 'h77);
        wr('h100, 'hEE);
        wr(2, 5);
        end_xfer(1);
        rd(5, 'h02, "R10 command kept");
        rd('h100, m_buf[0], "R10 buffer kept");
        rd(2, 3, "R10 config kept");

        // C: address count 7 acts as 4, no data (R4 R9)
        start_xfer(0, 7, 'hA1B2C3D4, 'hD8, 0, 1);
        end_xfer(1);
        rd(2, 7, "R4 raw address count readback");

        // D: count 300 clamped to 256, write, no address (R9 R7)
        start_xfer(0, 0, 0, 'h02, 300, 1);
        end_xfer(1);
        rd(6, 300 & 'hFF, "R9 count low kept");
        rd(7, 1, "R9 count high kept");

        // E: read with 4 address bytes on cs1 (R8 R4 R6)
        start_xfer(1, 4, 'h0BADF00D, 'h13, 3, 0);
        end_xfer(0);
        for (int i = 0; i < 3; i++) rd('h100 + i, m_buf[i], "R8 addressed read data");
        rd('h103, m_buf[3], "R8 byte beyond count untouched");

        // R2 return to direct mode, then start ignored
        wr(4, 'h30);
        wr(4, 'h31);
        repeat (20) @(negedge clk);
        rd(4, 'h30, "R2 direct mode again");

        finish_tb();
    end

endmodule